// File: doc/BRIEF.md
# Dual-Clock Dual-Port Synchronous RAM

This block is a shared word store with two fully independent access ports. Each port has its own clock and reset. On the rising edge of its clock, a port captures its address, its two select inputs, its write strobe, its write word and its output-mode input. Either port may read or write any word at any time. A word written through one port can be read back through the other port.

Each port has its own output timing. In flow mode, read data appears in the cycle that follows the capturing edge. In pipelined mode, the data passes through one more output register and appears one cycle later. The read side is modelled as a data bus plus a drive flag instead of tri-state pins. When the flag is low, the bus is held at zero. An active-low output enable clears the flag at once, without waiting for a clock edge. A write cycle, or a cycle in which the port is not selected, never drives the bus.

The address width is a parameter; 15 to 17 bits give 32K to 128K words. The default of 10 bits keeps elaboration small. The data width is also a parameter and is 8 or 9 bits.

Top module: `dpram_sync_dual`

## Requirements
- R1: A port is selected in a cycle only when its `cs_n` input is 0 and its `cs` input is 1 at the capturing edge. Any other combination makes the cycle idle: it does not write and it does not drive.
- R2: With `pipe_mode` = 0 at the capturing edge, a selected read (`write_n` = 1) sets `drive` and presents the word at the captured address from that edge until the next edge.
- R3: With `pipe_mode` = 1, the read word and the drive flag appear one clock later than in flow mode, after the following edge.
- R4: A selected cycle with `write_n` = 0 stores `wdata` at `addr`. The output does not drive for that cycle. In pipelined mode this quiet cycle is delayed by one clock, together with the data.
- R5: `out_en_n` = 1 clears `drive` combinationally, with no clock edge needed. Returning it to 0 restores the drive the registered state calls for.
- R6: Whenever `drive` is 0, `rdata` is all zeros.
- R7: In pipelined mode, a deselect shows on the output one clock after its capturing edge. On reselection, the first selected read edge leaves the bus undriven, and data is driven only after the next edge.
- R8: A word written through one port is returned by a read on the other port whose capturing edge comes at least one of that port's clock cycles after the write edge.
- R9: A write attempted while deselected leaves the stored word unchanged.
- R10: While a port's `rst_n` is 0, and after its release until its first selected read, that port does not drive and `rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_clk | input | 1 | Port A clock |
| a_rst_n | input | 1 | Port A asynchronous reset, active low |
| a_addr | input | ADDR_W | Port A word address |
| a_cs_n | input | 1 | Port A select, active low |
| a_cs | input | 1 | Port A select, active high |
| a_write_n | input | 1 | Port A write strobe, 0 = write, 1 = read |
| a_out_en_n | input | 1 | Port A asynchronous output enable, active low |
| a_pipe_mode | input | 1 | Port A output mode, 0 = flow, 1 = pipelined |
| a_wdata | input | DATA_W | Port A write word |
| a_rdata | output | DATA_W | Port A read word, zero when not driven |
| a_drive | output | 1 | Port A bus drive flag |
| b_clk | input | 1 | Port B clock |
| b_rst_n | input | 1 | Port B asynchronous reset, active low |
| b_addr | input | ADDR_W | Port B word address |
| b_cs_n | input | 1 | Port B select, active low |
| b_cs | input | 1 | Port B select, active high |
| b_write_n | input | 1 | Port B write strobe, 0 = write, 1 = read |
| b_out_en_n | input | 1 | Port B asynchronous output enable, active low |
| b_pipe_mode | input | 1 | Port B output mode, 0 = flow, 1 = pipelined |
| b_wdata | input | DATA_W | Port B write word |
| b_rdata | output | DATA_W | Port B read word, zero when not driven |
| b_drive | output | 1 | Port B bus drive flag |

## Verification
The hardest case to reach is a word that one clock domain writes and the other domain reads shortly afterwards, while both ports are busy. The second port runs on a 14 ns clock against the 10 ns first port, so the two sets of edges keep drifting relative to each other. A forked scenario drives a flow-mode write and read stream on one port and, at the same time, a pipelined stream on the other. It also reads words the opposite port wrote earlier, leaving one extra cycle of the reading port before it expects the new value. The pipelined deselect and reselect window is reached by switching the selects in the middle of a continuous read stream and sampling each of the two following edges.

// File: rtl/dpram_pkg.sv
package dpram_pkg;

  // Operation captured by a port at its clock edge
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // Read output timing
  typedef enum logic {
    MODE_FLOW = 1'b0,
    MODE_PIPE = 1'b1
  } out_mode_e;

  localparam int unsigned NUM_PORTS = 2;

  function automatic logic port_selected(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction

endpackage

// File: rtl/dpram_port_in.sv
module dpram_port_in
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              cs_n,
  input  logic              cs,
  input  logic              write_n,
  input  logic              pipe_mode,
  output logic              wr_en,
  output op_e               op_q,
  output logic [ADDR_W-1:0] addr_q,
  output out_mode_e         mode_q
);

  logic sel;

  assign sel   = port_selected(cs_n, cs);
  // write lands in the array on the same edge that captures the cycle
  assign wr_en = rst_n && sel && !write_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q   <= OP_IDLE;
      addr_q <= '0;
      mode_q <= MODE_FLOW;
    end else begin
      addr_q <= addr;
      mode_q <= pipe_mode ? MODE_PIPE : MODE_FLOW;
      if (!sel)
        op_q <= OP_IDLE;
      else if (write_n)
        op_q <= OP_READ;
      else
        op_q <= OP_WRITE;
    end
  end

endmodule

// File: rtl/dpram_lvt_array.sv
module dpram_lvt_array
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic [NUM_PORTS-1:0]             clk,
  input  logic [NUM_PORTS-1:0]             we,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] waddr,
  input  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata,
  input  logic [NUM_PORTS-1:0][ADDR_W-1:0] raddr,
  output logic [NUM_PORTS-1:0][DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = 1 << ADDR_W;

  // One bank per writing clock; each bank has its own owner tag bit.
  logic [DATA_W-1:0] bank_a [DEPTH];
  logic [DATA_W-1:0] bank_b [DEPTH];
  logic [DEPTH-1:0]  tag_a;
  logic [DEPTH-1:0]  tag_b;

  // Port A marks ownership by making its tag differ from B's
  always_ff @(posedge clk[0]) begin
    if (we[0]) begin
      bank_a[waddr[0]] <= wdata[0];
      tag_a[waddr[0]]  <= ~tag_b[waddr[0]];
    end
  end

  // Port B marks ownership by making its tag equal A's
  always_ff @(posedge clk[1]) begin
    if (we[1]) begin
      bank_b[waddr[1]] <= wdata[1];
      tag_b[waddr[1]]  <= tag_a[waddr[1]];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    logic a_owns;
    assign a_owns   = tag_a[raddr[p]] ^ tag_b[raddr[p]];
    assign rdata[p] = a_owns ? bank_a[raddr[p]] : bank_b[raddr[p]];
  end

endmodule

// File: rtl/dpram_read_out.sv
module dpram_read_out
  import dpram_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  op_e               op_q,
  input  out_mode_e         mode_q,
  input  logic [DATA_W-1:0] arr_rdata,
  input  logic              oe_n,
  output logic [DATA_W-1:0] rdata,
  output logic              drive
);

  logic              flow_drv;
  logic              pipe_drv;
  logic [DATA_W-1:0] pipe_data;
  logic              src_drv;
  logic [DATA_W-1:0] src_data;

  assign flow_drv = (op_q == OP_READ);

  // Extra stage: drive flag and word travel together
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_drv  <= 1'b0;
      pipe_data <= '0;
    end else begin
      pipe_drv  <= flow_drv;
      pipe_data <= arr_rdata;
    end
  end

  always_comb begin
    if (mode_q == MODE_PIPE) begin
      src_drv  = pipe_drv;
      src_data = pipe_data;
    end else begin
      src_drv  = flow_drv;
      src_data = arr_rdata;
    end
  end

  assign drive = src_drv && !oe_n;
  assign rdata = drive ? src_data : '0;

endmodule

// File: rtl/dpram_sync_dual.sv
module dpram_sync_dual
  import dpram_pkg::*;
#(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 8
) (
  input  logic              a_clk,
  input  logic              a_rst_n,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_cs_n,
  input  logic              a_cs,
  input  logic              a_write_n,
  input  logic              a_out_en_n,
  input  logic              a_pipe_mode,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  output logic              a_drive,
  input  logic              b_clk,
  input  logic              b_rst_n,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_cs_n,
  input  logic              b_cs,
  input  logic              b_write_n,
  input  logic              b_out_en_n,
  input  logic              b_pipe_mode,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata,
  output logic              b_drive
);

  logic [NUM_PORTS-1:0]             clk_v, rst_v, cs_n_v, cs_v, wr_n_v, oe_n_v, mode_v;
  logic [NUM_PORTS-1:0]             we_v, drive_v;
  logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v, addr_q_v;
  logic [NUM_PORTS-1:0][DATA_W-1:0] wdata_v, arr_rd_v, rdata_v;
  op_e                              op_q_v   [NUM_PORTS];
  out_mode_e                        mode_q_v [NUM_PORTS];

  assign clk_v   = {b_clk, a_clk};
  assign rst_v   = {b_rst_n, a_rst_n};
  assign cs_n_v  = {b_cs_n, a_cs_n};
  assign cs_v    = {b_cs, a_cs};
  assign wr_n_v  = {b_write_n, a_write_n};
  assign oe_n_v  = {b_out_en_n, a_out_en_n};
  assign mode_v  = {b_pipe_mode, a_pipe_mode};
  assign addr_v  = {b_addr, a_addr};
  assign wdata_v = {b_wdata, a_wdata};

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpram_port_in #(.ADDR_W(ADDR_W)) u_in (
      .clk       (clk_v[p]),
      .rst_n     (rst_v[p]),
      .addr      (addr_v[p]),
      .cs_n      (cs_n_v[p]),
      .cs        (cs_v[p]),
      .write_n   (wr_n_v[p]),
      .pipe_mode (mode_v[p]),
      .wr_en     (we_v[p]),
      .op_q      (op_q_v[p]),
      .addr_q    (addr_q_v[p]),
      .mode_q    (mode_q_v[p])
    );

    dpram_read_out #(.DATA_W(DATA_W)) u_out (
      .clk       (clk_v[p]),
      .rst_n     (rst_v[p]),
      .op_q      (op_q_v[p]),
      .mode_q    (mode_q_v[p]),
      .arr_rdata (arr_rd_v[p]),
      .oe_n      (oe_n_v[p]),
      .rdata     (rdata_v[p]),
      .drive     (drive_v[p])
    );
  end

  dpram_lvt_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk_v),
    .we    (we_v),
    .waddr (addr_v),
    .wdata (wdata_v),
    .raddr (addr_q_v),
    .rdata (arr_rd_v)
  );

  assign a_rdata = rdata_v[0];
  assign a_drive = drive_v[0];
  assign b_rdata = rdata_v[1];
  assign b_drive = drive_v[1];

endmodule

// File: rtl/dpram_sync_dual_chk.sv
module dpram_sync_dual_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              a_clk,
  input logic              a_rst_n,
  input logic              a_cs_n,
  input logic              a_cs,
  input logic              a_write_n,
  input logic              a_out_en_n,
  input logic              a_pipe_mode,
  input logic [DATA_W-1:0] a_rdata,
  input logic              a_drive,
  input logic              b_clk,
  input logic              b_rst_n,
  input logic              b_cs_n,
  input logic              b_cs,
  input logic              b_write_n,
  input logic              b_out_en_n,
  input logic              b_pipe_mode,
  input logic [DATA_W-1:0] b_rdata,
  input logic              b_drive
);

  logic a_sel, b_sel;
  assign a_sel = !a_cs_n && a_cs;
  assign b_sel = !b_cs_n && b_cs;

  // ---------------- port A ----------------
  a_r1_desel_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    ($past(a_rst_n) && !$past(a_sel) && !$past(a_pipe_mode)) |-> !a_drive);

  a_r2_flow_read_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    ($past(a_rst_n) && $past(a_sel && a_write_n) && !$past(a_pipe_mode) && !a_out_en_n) |-> a_drive);

  a_r3_pipe_read_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    ($past(a_rst_n, 2) && $past(a_pipe_mode) && $past(a_sel && a_write_n, 2) && !a_out_en_n) |-> a_drive);

  a_r4_write_quiet_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    ($past(a_rst_n) && $past(a_sel && !a_write_n) && !$past(a_pipe_mode)) |-> !a_drive);

  a_r5_oe_off_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    a_out_en_n |-> !a_drive);

  a_r6_zero_bus_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    !a_drive |-> (a_rdata == '0));

  a_r7_pipe_desel_a: assert property (@(posedge a_clk) disable iff (!a_rst_n)
    ($past(a_rst_n, 2) && $past(a_pipe_mode) && !$past(a_sel, 2)) |-> !a_drive);

  // ---------------- port B ----------------
  a_r1_desel_quiet_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    ($past(b_rst_n) && !$past(b_sel) && !$past(b_pipe_mode)) |-> !b_drive);

  a_r2_flow_read_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    ($past(b_rst_n) && $past(b_sel && b_write_n) && !$past(b_pipe_mode) && !b_out_en_n) |-> b_drive);

  a_r3_pipe_read_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    ($past(b_rst_n, 2) && $past(b_pipe_mode) && $past(b_sel && b_write_n, 2) && !b_out_en_n) |-> b_drive);

  a_r4_write_quiet_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    ($past(b_rst_n) && $past(b_sel && !b_write_n) && !$past(b_pipe_mode)) |-> !b_drive);

  a_r5_oe_off_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    b_out_en_n |-> !b_drive);

  a_r6_zero_bus_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    !b_drive |-> (b_rdata == '0));

  a_r7_pipe_desel_b: assert property (@(posedge b_clk) disable iff (!b_rst_n)
    ($past(b_rst_n, 2) && $past(b_pipe_mode) && !$past(b_sel, 2)) |-> !b_drive);

endmodule

bind dpram_sync_dual dpram_sync_dual_chk #(.DATA_W(DATA_W)) i_chk (
  .a_clk       (a_clk),
  .a_rst_n     (a_rst_n),
  .a_cs_n      (a_cs_n),
  .a_cs        (a_cs),
  .a_write_n   (a_write_n),
  .a_out_en_n  (a_out_en_n),
  .a_pipe_mode (a_pipe_mode),
  .a_rdata     (a_rdata),
  .a_drive     (a_drive),
  .b_clk       (b_clk),
  .b_rst_n     (b_rst_n),
  .b_cs_n      (b_cs_n),
  .b_cs        (b_cs),
  .b_write_n   (b_write_n),
  .b_out_en_n  (b_out_en_n),
  .b_pipe_mode (b_pipe_mode),
  .b_rdata     (b_rdata),
  .b_drive     (b_drive)
);

// File: tb/test_dpram_sync_dual.sv
module test_dpram_sync_dual;

  localparam int unsigned AW    = 10;
  localparam int unsigned DW    = 8;
  localparam int unsigned DEPTH = 1 << AW;

  logic a_clk = 1'b0, b_clk = 1'b0;
  logic a_rst_n = 1'b0, b_rst_n = 1'b0;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic a_cs_n = 1'b1, a_cs = 1'b0, a_write_n = 1'b1, a_out_en_n = 1'b0, a_pipe_mode = 1'b0;
  logic b_cs_n = 1'b1, b_cs = 1'b0, b_write_n = 1'b1, b_out_en_n = 1'b0, b_pipe_mode = 1'b0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic [DW-1:0] a_rdata, b_rdata;
  logic a_drive, b_drive;

  logic [DW-1:0] ref_mem [DEPTH];
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #5 a_clk = ~a_clk;   // 100 MHz
  always #7 b_clk = ~b_clk;   // independent second clock

  dpram_sync_dual #(.ADDR_W(AW), .DATA_W(DW)) i_dpram_sync_dual (
    .a_clk(a_clk), .a_rst_n(a_rst_n), .a_addr(a_addr), .a_cs_n(a_cs_n), .a_cs(a_cs),
    .a_write_n(a_write_n), .a_out_en_n(a_out_en_n), .a_pipe_mode(a_pipe_mode),
    .a_wdata(a_wdata), .a_rdata(a_rdata), .a_drive(a_drive),
    .b_clk(b_clk), .b_rst_n(b_rst_n), .b_addr(b_addr), .b_cs_n(b_cs_n), .b_cs(b_cs),
    .b_write_n(b_write_n), .b_out_en_n(b_out_en_n), .b_pipe_mode(b_pipe_mode),
    .b_wdata(b_wdata), .b_rdata(b_rdata), .b_drive(b_drive)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic a_set(input logic cs_n, input logic cs, input logic wr_n, input logic pm,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    a_cs_n = cs_n; a_cs = cs; a_write_n = wr_n; a_pipe_mode = pm; a_addr = ad; a_wdata = d;
  endtask

  task automatic b_set(input logic cs_n, input logic cs, input logic wr_n, input logic pm,
                       input logic [AW-1:0] ad, input logic [DW-1:0] d);
    b_cs_n = cs_n; b_cs = cs; b_write_n = wr_n; b_pipe_mode = pm; b_addr = ad; b_wdata = d;
  endtask

  task automatic a_tick; @(posedge a_clk); #1; endtask
  task automatic b_tick; @(posedge b_clk); #1; endtask

  task automatic t_reset;
    #30;
    check("R10 a_drive in reset", a_drive, 0);
    check("R10 b_drive in reset", b_drive, 0);
    a_rst_n = 1'b1; b_rst_n = 1'b1;
    a_tick(); b_tick();
    check("R10 a_drive after reset", a_drive, 0);
    check("R6 a_rdata zero when idle", a_rdata, 0);
    check("R10 b_drive after reset", b_drive, 0);
  endtask

  task automatic t_flow_rw;
    a_set(0, 1, 0, 0, 10'h005, 8'h3C); ref_mem[10'h005] = 8'h3C;
    a_tick();
    check("R4 no drive in flow write cycle", a_drive, 0);
    a_set(0, 1, 0, 0, 10'h006, 8'hA5); ref_mem[10'h006] = 8'hA5;
    a_tick();
    a_set(0, 1, 1, 0, 10'h005, 8'h00);
    a_tick();
    check("R2 flow read drive", a_drive, 1);
    check("R2 flow read data 005", a_rdata, 8'h3C);
    a_set(0, 1, 1, 0, 10'h006, 8'h00);
    a_tick();
    check("R2 flow read data 006", a_rdata, 8'hA5);
  endtask

  task automatic t_pipe;
    a_set(0, 1, 1, 1, 10'h005, 8'h00);        // pipelined read
    a_tick();
    a_set(0, 1, 0, 1, 10'h020, 8'h77); ref_mem[10'h020] = 8'h77;
    a_tick();
    check("R3 pipelined read drive", a_drive, 1);
    check("R3 pipelined read data", a_rdata, 8'h3C);
    a_set(0, 1, 1, 1, 10'h020, 8'h00);
    a_tick();
    check("R4 no drive one clock after pipelined write", a_drive, 0);
    a_tick();
    check("R3 pipelined read of new word", a_rdata, 8'h77);
  endtask

  task automatic t_desel;
    a_set(0, 1, 0, 0, 10'h010, 8'h11); ref_mem[10'h010] = 8'h11;
    a_tick();
    a_set(1, 1, 0, 0, 10'h010, 8'hEE);        // cs_n high
    a_tick();
    check("R1 deselected write does not drive", a_drive, 0);
    a_set(0, 0, 0, 0, 10'h010, 8'hDD);        // cs low
    a_tick();
    a_set(1, 0, 1, 0, 10'h010, 8'h00);        // deselected read
    a_tick();
    check("R1 deselected read does not drive", a_drive, 0);
    check("R6 rdata zero while deselected", a_rdata, 0);
    a_set(0, 1, 1, 0, 10'h010, 8'h00);
    a_tick();
    check("R9 deselected writes ignored", a_rdata, 8'h11);
  endtask

  task automatic t_oe;
    a_set(0, 1, 1, 0, 10'h010, 8'h00);
    a_tick();
    check("R5 drive with out_en_n low", a_drive, 1);
    #1 a_out_en_n = 1'b1;
    #1;
    check("R5 out_en_n high clears drive", a_drive, 0);
    check("R6 rdata zero with out_en_n high", a_rdata, 0);
    #1 a_out_en_n = 1'b0;
    #1;
    check("R5 drive restored without clock", a_drive, 1);
    check("R5 data restored", a_rdata, 8'h11);
  endtask

  task automatic t_pipe_reselect;
    a_set(0, 1, 1, 1, 10'h010, 8'h00);
    a_tick(); a_tick();
    check("R3 steady pipelined read", a_rdata, 8'h11);
    a_set(1, 0, 1, 1, 10'h010, 8'h00);
    a_tick();
    check("R7 deselect not yet visible", a_drive, 1);
    a_tick();
    check("R7 deselect visible one clock later", a_drive, 0);
    a_set(0, 1, 1, 1, 10'h010, 8'h00);
    a_tick();
    check("R7 first reselected edge still quiet", a_drive, 0);
    a_tick();
    check("R7 drive after reselect", a_drive, 1);
    check("R7 data after reselect", a_rdata, 8'h11);
    a_set(1, 0, 1, 0, 10'h000, 8'h00);
    a_tick(); a_tick();
  endtask

  task automatic t_cross;
    a_set(0, 1, 0, 0, 10'h030, 8'h5A); ref_mem[10'h030] = 8'h5A;
    a_tick();
    a_set(1, 0, 1, 0, 10'h000, 8'h00);
    b_set(0, 1, 1, 0, 10'h030, 8'h00);
    b_tick(); b_tick();
    check("R8 B reads word written by A", b_rdata, 8'h5A);
    b_set(0, 1, 0, 1, 10'h031, 8'hC3); ref_mem[10'h031] = 8'hC3;
    b_tick();
    b_set(1, 0, 1, 1, 10'h000, 8'h00);
    a_set(0, 1, 1, 0, 10'h031, 8'h00);
    a_tick(); a_tick();
    check("R8 A reads word written by B", a_rdata, 8'hC3);
    a_set(1, 0, 1, 0, 10'h000, 8'h00);
    b_tick(); b_tick();
  endtask

  task automatic a_stream;
    for (int i = 0; i < 8; i++) begin
      a_set(0, 1, 0, 0, AW'(10'h100 + i), DW'(8'h40 + i));
      ref_mem[10'h100 + i] = DW'(8'h40 + i);
      a_tick();
    end
    for (int i = 0; i < 8; i++) begin
      a_set(0, 1, 1, 0, AW'(10'h100 + i), 8'h00);
      a_tick();
      check("R2 concurrent flow readback", a_rdata, ref_mem[10'h100 + i]);
    end
    a_set(1, 0, 1, 0, 10'h000, 8'h00);
  endtask

  task automatic b_stream;
    for (int i = 0; i < 8; i++) begin
      b_set(0, 1, 0, 1, AW'(10'h200 + i), DW'(8'h90 + i));
      ref_mem[10'h200 + i] = DW'(8'h90 + i);
      b_tick();
    end
    for (int i = 0; i < 8; i++) begin
      b_set(0, 1, 1, 1, AW'(10'h200 + i), 8'h00);
      b_tick(); b_tick();
      check("R3 concurrent pipelined readback", b_rdata, ref_mem[10'h200 + i]);
    end
    b_set(0, 1, 1, 1, 10'h006, 8'h00);
    b_tick(); b_tick();
    check("R8 concurrent B read of A word", b_rdata, ref_mem[10'h006]);
    b_set(1, 0, 1, 0, 10'h000, 8'h00);
  endtask

  task automatic t_concurrent;
    fork
      a_stream();
      b_stream();
    join
  endtask

  task automatic summary;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  endtask

  initial begin
    t_reset();
    t_flow_rw();
    t_pipe();
    t_desel();
    t_oe();
    t_pipe_reselect();
    t_cross();
    t_concurrent();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (20000) @(posedge a_clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
    end
  end

endmodule